// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to thirty level-sensitive interrupt lines from peripherals and presents them to a processor core as a single request wire plus an 8-bit vector bus. Each line is sampled every cycle into a raw-status register. A software-owned enable mask gates the raw status into a masked status, and the vector logic encodes that masked status.

The vector tells the core either which single source is pending, or only that several are pending. In the second case software reads the masked-status register and applies its own priority order. The hardware holds no priority logic at all.

A small 32-bit word register interface gives access to several registers:
- the enable mask;
- the raw and masked status, which are read-only views;
- two plain 32-bit storage registers for non-maskable-event status and error status.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the mask, the non-maskable status and the error status read 0, the request output is low, the vector output is 0 and the error strobe is low.
- R2: A read of offset 0x04 returns the line levels sampled on the previous clock edge in bits 29:0, with bits 31:30 zero. Read data appears on the cycle after the access edge.
- R3: A read of offset 0x08 returns the raw status ANDed with the mask.
- R4: When exactly one masked bit i is set, the vector output becomes 0x31 + i and the request goes high. Both appear two clock edges after the line changes.
- R5: When two or more masked bits are set, the vector output is 0x30 and the request is high.
- R6: When no masked bit is set, the request is low and the vector output is 0.
- R7: The mask at offset 0x00 is 30 bits wide, and bits 31:30 read 0. A mask write changes the request and vector outputs on the clock edge after the write edge.
- R8: Offsets 0x0C (non-maskable status) and 0x10 (error status) are 32-bit registers that read back the last value written.
- R9: Writes to offsets 0x04 and 0x08 are ignored. The mask is unchanged, and both offsets keep reflecting the lines.
- R10: An access to any other offset, including an unaligned one, pulses the error strobe for one cycle after the access edge. A read there returns 0, and a write there changes no register.
- R11: The request and vector outputs are registered together. The request is high exactly when the vector is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 30 | Level-sensitive interrupt lines |
| bus_sel_i | input | 1 | Register access strobe for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered, held until the next read |
| bus_err_o | output | 1 | One-cycle strobe for an undefined offset |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 8 | Interrupt vector to the core |

## Verification
A corrupted mask or raw sample shows at the request and vector outputs within two edges. Depending on the fault, it appears as a wrong single-source vector, a false "multiple" code 0x30, or a request that never rises. The reference model compares those outputs, the error strobe and the read data after every edge, so a divergence is reported in the cycle it first becomes visible. Ignored writes are made visible by reading back the mask and the status views directly after each such write.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [2:0] {
    SLOT_MASK,
    SLOT_RAW,
    SLOT_MASKED,
    SLOT_NMI,
    SLOT_DIAG,
    SLOT_NONE
  } slot_e;

  function automatic slot_e decode_slot(input logic [ADDR_W-1:0] a);
    case (a)
      5'h00:   return SLOT_MASK;
      5'h04:   return SLOT_RAW;
      5'h08:   return SLOT_MASKED;
      5'h0C:   return SLOT_NMI;
      5'h10:   return SLOT_DIAG;
      default: return SLOT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqv_sampler.sv
module irqv_sampler #(
  parameter int unsigned NUM_LINES = 30
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] lines_i,
  output logic [NUM_LINES-1:0] raw_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) raw_o[g] <= 1'b0;
      else         raw_o[g] <= lines_i[g];
    end
  end
endmodule

// File: rtl/irqv_encoder.sv
module irqv_encoder #(
  parameter int unsigned NUM_LINES = 30,
  parameter int unsigned VEC_W     = 8,
  parameter logic [7:0]  BASE_VEC  = 8'h30
) (
  input  logic [NUM_LINES-1:0] masked_i,
  output logic                 req_o,
  output logic [VEC_W-1:0]     vec_o
);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);

  logic [IDX_W-1:0] low_idx;
  logic             multi;

  always_comb begin
    low_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (masked_i[i]) low_idx = IDX_W'(i);
    end
  end

  // clearing the lowest set bit leaves something only if two or more were set
  assign multi = |(masked_i & (masked_i - NUM_LINES'(1)));
  assign req_o = |masked_i;

  always_comb begin
    if (!req_o)     vec_o = '0;
    else if (multi) vec_o = VEC_W'(BASE_VEC);
    else            vec_o = VEC_W'(BASE_VEC) + VEC_W'(1) + VEC_W'(low_idx);
  end
endmodule

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_LINES = 30,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_LINES-1:0] raw_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 err_o,
  output logic [NUM_LINES-1:0] mask_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_LINES;

  logic [DATA_W-1:0] nmi_q, diag_q, rd_mux;
  slot_e             slot;

  assign slot = decode_slot(addr_i);

  always_comb begin
    case (slot)
      SLOT_MASK:   rd_mux = {{PAD_W{1'b0}}, mask_o};
      SLOT_RAW:    rd_mux = {{PAD_W{1'b0}}, raw_i};
      SLOT_MASKED: rd_mux = {{PAD_W{1'b0}}, raw_i & mask_o};
      SLOT_NMI:    rd_mux = nmi_q;
      SLOT_DIAG:   rd_mux = diag_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o  <= '0;
      nmi_q   <= '0;
      diag_q  <= '0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= sel_i && (slot == SLOT_NONE);
      if (sel_i && !we_i) rdata_o <= rd_mux;
      if (sel_i && we_i) begin
        case (slot)
          SLOT_MASK: mask_o <= wdata_i[NUM_LINES-1:0];
          SLOT_NMI:  nmi_q  <= wdata_i;
          SLOT_DIAG: diag_q <= wdata_i;
          default:   ;  // status views are read-only, unknown offsets drop
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_LINES = 30,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned VEC_W     = 8,
  parameter logic [7:0]  BASE_VEC  = 8'h30
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 bus_err_o,
  output logic                 irq_req_o,
  output logic [VEC_W-1:0]     irq_vec_o
);
  logic [NUM_LINES-1:0] raw_q, mask_q;
  logic                 req_d;
  logic [VEC_W-1:0]     vec_d;

  irqv_sampler #(.NUM_LINES(NUM_LINES)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lines_i(irq_lines_i),
    .raw_o  (raw_q)
  );

  irqv_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (bus_sel_i),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i),
    .raw_i  (raw_q),
    .rdata_o(bus_rdata_o),
    .err_o  (bus_err_o),
    .mask_o (mask_q)
  );

  irqv_encoder #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .BASE_VEC(BASE_VEC)) u_enc (
    .masked_i(raw_q & mask_q),
    .req_o   (req_d),
    .vec_o   (vec_d)
  );

  // one register stage for both so the core never sees a mismatched pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_req_o <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      irq_req_o <= req_d;
      irq_vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int unsigned NUM_LINES = 30,
  parameter int unsigned VEC_W     = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sel_i,
  input logic                 we_i,
  input logic [4:0]           addr_i,
  input logic                 err_i,
  input logic                 req_i,
  input logic [VEC_W-1:0]     vec_i,
  input logic [NUM_LINES-1:0] mask_i
);
  AST_REQ_VEC_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i == (vec_i != '0));  // R11

  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_i == '0) || ((vec_i >= VEC_W'(8'h30)) && (vec_i <= VEC_W'(8'h30 + NUM_LINES))));  // R4

  AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> $past(sel_i));  // R10

  AST_MASK_OFF_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> !req_i);  // R7

  AST_STATUS_WRITE_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && (addr_i == 5'h04 || addr_i == 5'h08)) |=> $stable(mask_i));  // R9
endmodule

bind irq_vector_ctrl irqv_checker #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .sel_i (bus_sel_i),
  .we_i  (bus_we_i),
  .addr_i(bus_addr_i),
  .err_i (bus_err_o),
  .req_i (irq_req_o),
  .vec_i (irq_vec_o),
  .mask_i(mask_q)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] lines = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, req;
  logic [7:0]  vec;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_err_o(err), .irq_req_o(req), .irq_vec_o(vec)
  );

  // behavioural reference, advanced on each rising edge
  logic [31:0] m_mask, m_raw, m_nmi, m_diag, m_rdata;
  logic        m_err, m_req;
  logic [7:0]  m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = 0; m_raw = 0; m_nmi = 0; m_diag = 0; m_rdata = 0;
      m_err = 0; m_req = 0; m_vec = 0;
    end else begin
      logic [31:0] mv;
      int n, first;
      mv = m_raw & m_mask;
      n = 0; first = -1;
      for (int i = 0; i < 30; i++) if (mv[i]) begin n++; if (first < 0) first = i; end
      m_err = 0;
      if (sel) begin
        case (addr)
          5'h00: if (we) m_mask = {2'b00, wdata[29:0]}; else m_rdata = m_mask;
          5'h04: if (!we) m_rdata = m_raw;
          5'h08: if (!we) m_rdata = mv;
          5'h0C: if (we) m_nmi = wdata; else m_rdata = m_nmi;
          5'h10: if (we) m_diag = wdata; else m_rdata = m_diag;
          default: begin m_err = 1; if (!we) m_rdata = 0; end
        endcase
      end
      m_raw = {2'b00, lines};
      m_req = (n != 0);
      m_vec = (n == 0) ? 8'h00 : (n == 1) ? 8'(8'h31 + first) : 8'h30;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    check("R11 req", 32'(req), 32'(m_req));
    check("R11 vec", 32'(vec), 32'(m_vec));
    check("R10 err", 32'(err), 32'(m_err));
    check("R2 rdata", rdata, m_rdata);
  end

  task automatic wr(logic [4:0] a, logic [31:0] d, output logic e);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0; e = err;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); sel = 1; we = 0; addr = a;
    @(negedge clk); sel = 0; d = rdata; e = err;
  endtask

  task automatic set_lines(logic [29:0] v);
    @(negedge clk); lines = v;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    check("R1 req", 32'(req), 0); check("R1 vec", 32'(vec), 0); check("R1 err", 32'(err), 0);
    rd(5'h00, d, e); check("R1 mask", d, 0);
    rd(5'h0C, d, e); check("R1 nmi", d, 0);
    rd(5'h10, d, e); check("R1 diag", d, 0);
    // R7 width
    wr(5'h00, 32'hFFFF_FFFF, e);
    rd(5'h00, d, e); check("R7 mask width", d, 32'h3FFF_FFFF);
    // R4 single
    set_lines(30'h1);
    check("R4 vec line0", 32'(vec), 32'h31); check("R4 req", 32'(req), 1);
    set_lines(30'h2000_0000);
    check("R4 vec line29", 32'(vec), 32'h4E);
    // R5 multiple
    set_lines(30'h88);
    check("R5 vec multi", 32'(vec), 32'h30); check("R5 req", 32'(req), 1);
    rd(5'h04, d, e); check("R2 raw", d, 32'h88);
    // R6 none
    set_lines(30'h0);
    check("R6 vec", 32'(vec), 0); check("R6 req", 32'(req), 0);
    // R7 mask timing and R3
    set_lines(30'h88);
    wr(5'h00, 32'h80, e);
    check("R7 before edge", 32'(vec), 32'h30);
    @(negedge clk);
    check("R7 after mask", 32'(vec), 32'h38);
    rd(5'h08, d, e); check("R3 masked", d, 32'h80);
    wr(5'h00, 32'h0, e);
    @(negedge clk);
    check("R7 mask off", 32'(req), 0);
    // R9
    wr(5'h04, 32'hFFFF_FFFF, e);
    wr(5'h08, 32'hFFFF_FFFF, e);
    rd(5'h00, d, e); check("R9 mask kept", d, 0);
    rd(5'h04, d, e); check("R9 raw kept", d, 32'h88);
    rd(5'h08, d, e); check("R9 masked kept", d, 0);
    // R8
    wr(5'h0C, 32'hA5A5_5A5A, e);
    wr(5'h10, 32'h1234_5678, e);
    rd(5'h0C, d, e); check("R8 nmi", d, 32'hA5A5_5A5A);
    rd(5'h10, d, e); check("R8 diag", d, 32'h1234_5678);
    // R10
    wr(5'h14, 32'hFFFF_FFFF, e); check("R10 err write", 32'(e), 1);
    @(negedge clk); check("R10 one cycle", 32'(err), 0);
    rd(5'h02, d, e); check("R10 read zero", d, 0); check("R10 err read", 32'(e), 1);
    wr(5'h1C, 32'h0, e);
    rd(5'h0C, d, e); check("R10 nmi kept", d, 32'hA5A5_5A5A);
    rd(5'h00, d, e); check("R10 mask kept", d, 0);
    // mixed traffic, compared each cycle by the model
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      lines = 30'($urandom) & ((k % 3 == 0) ? 30'h3FFF_FFFF : 30'(1 << ($urandom % 30)));
      if (k % 17 == 0) begin sel = 1; we = 1; addr = 5'h00; wdata = $urandom; end
      else if (k % 7 == 0) begin sel = 1; we = 0; addr = 5'($urandom % 24); end
      else sel = 0;
    end
    @(negedge clk); sel = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule